// File: doc/BRIEF.md
# Framed Serial Write Port

This block is the write side of a serial port for a converter-style peripheral. A host drives a serial clock, a serial data line and a separate latch line. Each rising serial-clock edge pushes one data bit into a 24-bit input word, most significant bit first. The serial lines and the latch are sampled in a faster system clock, and the port counts the serial-clock edges seen since the last latch strobe.

A rising edge on the latch line is a commit request. If exactly 24 serial-clock edges arrived since the previous latch rising edge, the upper 8 bits of the word go to the address output and the lower 16 bits go to the data output. A one-cycle write strobe marks the update. Any other edge count, including a single stray edge ahead of an otherwise well-formed word, rejects the frame. In that case the outputs keep their old values and a sticky frame-error flag is raised. Shifting never pauses: bits clocked while the latch line is high count toward the next frame.

Top module: `sfw_write_port`

## Requirements
- R1: After reset, addr_o and data_o are zero and wr_stb_o and frame_err_o are low.
- R2: Serial bits enter the word most significant bit first: the first bit clocked into a 24-bit frame lands in bit 23 of the committed word.
- R3: On a commit, addr_o takes word bits 23..16 and data_o takes word bits 15..0.
- R4: A latch rising edge that follows exactly 24 serial-clock rising edges since the previous latch rising edge (or since reset) updates addr_o and data_o and pulses wr_stb_o high for exactly one system clock cycle.
- R5: A latch rising edge that follows fewer than 24 serial-clock edges leaves addr_o and data_o unchanged, gives no wr_stb_o pulse and sets frame_err_o.
- R6: A latch rising edge that follows more than 24 serial-clock edges is rejected in the same way as R5, even when the last 24 bits form a well-formed word.
- R7: Serial-clock edges that occur while the latch line is high are shifted in and counted toward the next frame.
- R8: frame_err_o stays high until reset once it is set. A later valid frame still updates the outputs.
- R9: The edge count restarts at every latch rising edge, valid or not, so a correct 24-bit frame after a rejected one is accepted.
- R10: The edge count saturates one above the frame length and never wraps. A frame of 56 edges is rejected.
- R11: A falling edge on the latch line, and a latch line that simply stays high, cause no commit and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; each rising edge shifts one bit |
| sdin_i | input | 1 | Serial data, most significant bit first |
| latch_i | input | 1 | Commit request on its rising edge |
| addr_o | output | 8 | Address field of the last accepted frame |
| data_o | output | 16 | Data field of the last accepted frame |
| wr_stb_o | output | 1 | One-cycle pulse when a frame is accepted |
| frame_err_o | output | 1 | Sticky flag: some frame had a wrong edge count |

## Verification
The hardest case to reach from the ports is an overlong frame whose edge count would land back on exactly 24 if the counter wrapped. Reaching it needs a 5-bit counter to pass 32, so the bench sends 56 edges that end in a well-formed word and expects a rejection. The bench also runs the stray-edge case: one extra leading edge ahead of a clean word. For frames clocked while the latch line is held high, the bench checks that the latch's falling edge commits nothing and that the following rising edge commits the bits that arrived during the high phase.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    localparam int SFW_WORD_W   = 24;
    localparam int SFW_ADDR_W   = 8;
    localparam int SFW_STAGES   = 2;

    // Outcome of one system clock cycle at the commit stage
    typedef enum logic [1:0] {
        VERDICT_IDLE = 2'd0,
        VERDICT_GOOD = 2'd1,
        VERDICT_BAD  = 2'd2
    } verdict_e;

endpackage

// File: rtl/sfw_edge.sv
// Per-lane synchronizer chain followed by a rising-edge detector.
module sfw_edge #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_lane
            logic [STAGES-1:0] chain_d, chain_q;
            logic              prev_d,  prev_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], async_i[g]};
                prev_d  = chain_q[STAGES-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                    prev_q  <= 1'b0;
                end else begin
                    chain_q <= chain_d;
                    prev_q  <= prev_d;
                end
            end

            assign level_o[g] = chain_q[STAGES-1];
            assign rise_o[g]  = chain_q[STAGES-1] & ~prev_q;
        end
    endgenerate

endmodule

// File: rtl/sfw_shifter.sv
// Input word shift register and saturating edge counter.
module sfw_shifter #(
    parameter int WORD_W = 24,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              restart,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.word = {st_q.word[WORD_W-2:0], bit_in};
        end
        if (restart) begin
            // an edge in the same cycle as the strobe opens the next frame
            st_d.cnt = shift_en ? CNT_W'(1) : '0;
        end else if (shift_en && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/sfw_commit.sv
// Judges each latch strobe and drives the committed fields.
module sfw_commit
    import sfw_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe,
    input  logic [CNT_W-1:0]         cnt,
    input  logic [WORD_W-1:0]        word,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [WORD_W-ADDR_W-1:0] data_o,
    output logic                     stb_o,
    output logic                     err_o
);

    localparam int DATA_W = WORD_W - ADDR_W;
    localparam logic [CNT_W-1:0] CNT_EXACT = CNT_W'(WORD_W);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              stb;
        logic              err;
    } cmt_t;

    cmt_t     st_d, st_q;
    verdict_e verdict;

    always_comb begin
        if (!strobe) begin
            verdict = VERDICT_IDLE;
        end else if (cnt == CNT_EXACT) begin
            verdict = VERDICT_GOOD;
        end else begin
            verdict = VERDICT_BAD;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        case (verdict)
            VERDICT_GOOD: begin
                st_d.addr = word[WORD_W-1:DATA_W];
                st_d.data = word[DATA_W-1:0];
                st_d.stb  = 1'b1;
            end
            VERDICT_BAD: begin
                st_d.err  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
    assign data_o = st_q.data;
    assign stb_o  = st_q.stb;
    assign err_o  = st_q.err;

endmodule

// File: rtl/sfw_write_port.sv
module sfw_write_port
    import sfw_pkg::*;
#(
    parameter int WORD_W = SFW_WORD_W,
    parameter int ADDR_W = SFW_ADDR_W,
    parameter int STAGES = SFW_STAGES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk_i,
    input  logic                     sdin_i,
    input  logic                     latch_i,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [WORD_W-ADDR_W-1:0] data_o,
    output logic                     wr_stb_o,
    output logic                     frame_err_o
);

    localparam int CNT_W    = $clog2(WORD_W + 2);
    localparam int LANES    = 3;
    localparam int LN_SCLK  = 0;
    localparam int LN_SDIN  = 1;
    localparam int LN_LATCH = 2;

    logic [LANES-1:0]  lane_level;
    logic [LANES-1:0]  lane_rise;
    logic              sclk_rise;
    logic              latch_rise;
    logic              sdin_bit;
    logic [WORD_W-1:0] in_word;
    logic [CNT_W-1:0]  edge_cnt;

    sfw_edge #(
        .WIDTH  (LANES),
        .STAGES (STAGES)
    ) edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({latch_i, sdin_i, sclk_i}),
        .level_o (lane_level),
        .rise_o  (lane_rise)
    );

    assign sclk_rise  = lane_rise[LN_SCLK];
    assign latch_rise = lane_rise[LN_LATCH];
    assign sdin_bit   = lane_level[LN_SDIN];

    sfw_shifter #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise),
        .bit_in   (sdin_bit),
        .restart  (latch_rise),
        .word_o   (in_word),
        .cnt_o    (edge_cnt)
    );

    sfw_commit #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) cmt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (latch_rise),
        .cnt    (edge_cnt),
        .word   (in_word),
        .addr_o (addr_o),
        .data_o (data_o),
        .stb_o  (wr_stb_o),
        .err_o  (frame_err_o)
    );

endmodule

// File: rtl/sfw_write_port_chk.sv
module sfw_write_port_chk #(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     latch_rise,
    input logic [CNT_W-1:0]         cnt,
    input logic [ADDR_W-1:0]        addr_o,
    input logic [WORD_W-ADDR_W-1:0] data_o,
    input logic                     wr_stb_o,
    input logic                     frame_err_o
);

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o); // R4

    AST_STB_EXACT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> ($past(latch_rise) && ($past(cnt) == CNT_W'(WORD_W)))); // R6

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_o |-> ($stable(addr_o) && $stable(data_o))); // R5

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err_o) |-> ($past(latch_rise) && ($past(cnt) != CNT_W'(WORD_W)))); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> frame_err_o); // R8

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WORD_W + 1)); // R10

endmodule

bind sfw_write_port sfw_write_port_chk #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_rise  (latch_rise),
    .cnt         (edge_cnt),
    .addr_o      (addr_o),
    .data_o      (data_o),
    .wr_stb_o    (wr_stb_o),
    .frame_err_o (frame_err_o)
);

// File: tb/sfw_write_port_tb.sv
`timescale 1ns/1ps
module sfw_write_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdin = 1'b0;
    logic        latch = 1'b0;
    logic [7:0]  addr;
    logic [15:0] data;
    logic        wr_stb;
    logic        frame_err;

    int checks = 0;
    int failures = 0;
    int stb_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sfw_write_port dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk),
        .sdin_i      (sdin),
        .latch_i     (latch),
        .addr_o      (addr),
        .data_o      (data),
        .wr_stb_o    (wr_stb),
        .frame_err_o (frame_err)
    );

    always @(negedge clk) begin
        if (rst_n && wr_stb) stb_seen++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sclk = 1'b0; sdin = 1'b0; latch = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(4);
        stb_seen = 0;
    endtask

    task automatic send_bit(input logic b);
        sdin = b;
        idle(5);
        sclk = 1'b1;
        idle(5);
        sclk = 1'b0;
    endtask

    // sends the lowest n bits of w, most significant of them first
    task automatic send_bits(input logic [23:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic latch_up();
        idle(3);
        latch = 1'b1;
        idle(10);
    endtask

    task automatic latch_down();
        latch = 1'b0;
        idle(10);
    endtask

    task automatic pulse_latch();
        latch_up();
        latch_down();
    endtask

    task automatic expect_out(input string req, input logic [7:0] ea,
                              input logic [15:0] ed, input int estb, input bit eerr);
        check(addr == ea, req, "addr", 32'(addr), 32'(ea));
        check(data == ed, req, "data", 32'(data), 32'(ed));
        check(stb_seen == estb, req, "strobes", 32'(stb_seen), 32'(estb));
        check(frame_err == eerr, req, "frame_err", 32'(frame_err), 32'(eerr));
    endtask

    task automatic t_reset();
        do_reset();
        expect_out("R1", 8'h00, 16'h0000, 0, 1'b0);
        check(wr_stb == 1'b0, "R1", "wr_stb", 32'(wr_stb), 32'd0);
    endtask

    task automatic t_valid();
        do_reset();
        send_bits(24'hA51234, 24);
        pulse_latch();
        expect_out("R2", 8'hA5, 16'h1234, 1, 1'b0);
        send_bits(24'h3CF00F, 24);
        pulse_latch();
        expect_out("R3", 8'h3C, 16'hF00F, 2, 1'b0);
        send_bits(24'h800001, 24);
        pulse_latch();
        expect_out("R4", 8'h80, 16'h0001, 3, 1'b0);
    endtask

    task automatic t_short_then_recover();
        do_reset();
        send_bits(24'h112233, 24);
        pulse_latch();
        send_bits(24'h445566, 23);
        pulse_latch();
        expect_out("R5", 8'h11, 16'h2233, 1, 1'b1);
        send_bits(24'h778899, 24);
        pulse_latch();
        expect_out("R9", 8'h77, 16'h8899, 2, 1'b1);
        check(frame_err == 1'b1, "R8", "sticky", 32'(frame_err), 32'd1);
    endtask

    task automatic t_extra_edge();
        do_reset();
        send_bit(1'b1);
        send_bits(24'h5AC3E1, 24);
        pulse_latch();
        expect_out("R6", 8'h00, 16'h0000, 0, 1'b1);
    endtask

    task automatic t_wrap();
        do_reset();
        send_bits(24'hFFFFFF, 24);
        send_bits(24'h0000FF, 8);
        send_bits(24'hC0FFEE, 24);
        pulse_latch();
        expect_out("R10", 8'h00, 16'h0000, 0, 1'b1);
    endtask

    task automatic t_shift_while_high();
        do_reset();
        send_bits(24'h0102AB, 24);
        latch_up();
        send_bits(24'hE7BEEF, 24);
        expect_out("R11", 8'h01, 16'h02AB, 1, 1'b0);
        latch_down();
        expect_out("R11", 8'h01, 16'h02AB, 1, 1'b0);
        pulse_latch();
        expect_out("R7", 8'hE7, 16'hBEEF, 2, 1'b0);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        t_reset();
        t_valid();
        t_short_then_recover();
        t_extra_edge();
        t_wrap();
        t_shift_while_high();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

endmodule